// File: doc/BRIEF.md
# Smart Battery Charge Request Controller

This block is the digital control core of a smart battery charger. A serial-bus slave front end decodes two kinds of host or battery write: a charging-current request in mA and a charging-voltage request in mV. The block turns them into two 10-bit DAC codes and a charge-enable level. It applies a selectable ceiling to each request and divides by the step size that goes with that ceiling.

While no request pair has arrived since the battery went in, the block supplies a small fixed wake-up current. A watchdog counts prescaled ticks. If no fresh pair of requests arrives in time, charging drops back to wake-up current. If wake-up itself runs out of time, charging stops.

The thermistor class can hold the battery in wake-up or force charging off. A status word collects presence, over-range, power-fail and thermistor flags. Any change in the status word pulls an active-low interrupt until the host reads the status.

Top module: `chargeReqCtl`

## Requirements
- R1: With all inputs low during reset, after reset both DAC codes are 0, `chgEn` is 0, `intN` is 1 and `statusWord` is 0.
- R2: When `batPresent` rises, the block enters wake-up two clock edges later. In wake-up, `iDacCode` is WAKE_MA (80 mA) divided by the current step and rounded down, `vDacCode` is the ceiling code of the selected voltage range, and `chgEn` is 1. Wake-up lasts until both a current write and a voltage write have been seen.
- R3: Once both requests have been written with the thermistor class normal, the block charges. In this state `iDacCode` is min(request, 1023·2^sel) shifted right by `iRangeSel` (step 2^sel mA). The codes appear one edge after the completing write.
- R4: `vRangeSel` picks the voltage ceiling and step. Value 0 gives 8400 mV with a 16 mV step, 1 gives 12600/16, 2 gives 16800/32, 3 gives 21000/32, and 4 or above gives 32736/32. `vDacCode` is the clamped request shifted by the step and never exceeds the ceiling code.
- R5: `statusWord[2]` is set while the stored current request exceeds its ceiling. `statusWord[3]` is set while the stored voltage request exceeds its ceiling.
- R6: If either code would be 0, `chgEn` is 0.
- R7: While charging, if no new request pair completes for PRESCALE·TIMEOUT_TICKS cycles, the block returns to wake-up.
- R8: If wake-up lasts PRESCALE·TIMEOUT_TICKS cycles without a completed pair, codes and `chgEn` go to 0. A later completed pair resumes charging.
- R9: Thermistor class 1 (cold) or 2 (under-range) keeps or returns the block to wake-up current. These classes set `statusWord[5]` or `statusWord[6]` respectively.
- R10: Thermistor class 3 (hot) forces both codes and `chgEn` to 0 one edge later and sets `statusWord[7]`.
- R11: When `batPresent` is low, both codes and `chgEn` are 0 one edge later. Re-insertion restarts at wake-up.
- R12: `statusWord[0]` mirrors battery presence, `statusWord[1]` mirrors adapter presence and `statusWord[4]` mirrors `pwrFailCmp`, each one edge late.
- R13: Any change of `statusWord` drives `intN` low in the same cycle. `intN` stays low until a `statusRd` pulse. A change in the read cycle wins over the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqCurWr | input | 1 | Strobe: `reqData` is a current request (mA) |
| reqVoltWr | input | 1 | Strobe: `reqData` is a voltage request (mV) |
| reqData | input | 16 | Decoded request value |
| iRangeSel | input | 2 | Current ceiling/step select |
| vRangeSel | input | 3 | Voltage ceiling/step select |
| batPresent | input | 1 | Battery present |
| thermState | input | 2 | Thermistor class: 0 normal, 1 cold, 2 under-range, 3 hot |
| acPresent | input | 1 | Adapter present |
| pwrFailCmp | input | 1 | Battery above 89% of adapter voltage |
| statusRd | input | 1 | Host read of status, clears interrupt |
| iDacCode | output | 10 | Current DAC code |
| vDacCode | output | 10 | Voltage DAC code |
| chgEn | output | 1 | Charger enable, low disables |
| intN | output | 1 | Active-low interrupt |
| statusWord | output | 8 | Status flags |

## Verification
The properties assume that `thermState`, `vRangeSel`, `batPresent` and the status inputs are synchronous to `clk`. They also assume that a write strobe lasts exactly one cycle. The bench drives every input on the falling edge, one strobe at a time, so each request is sampled on exactly one rising edge. Range selects are changed only while no write is in flight, so each expected code depends on a single, known ceiling.

// File: rtl/chargeReqPkg.sv
`timescale 1ns/1ps
package chargeReqPkg;

  typedef enum logic [1:0] {SEL_OFF, SEL_WAKE, SEL_REQ} outSel_e;

  typedef struct packed {
    outSel_e outSel;
  } chgCtl_t;

  localparam logic [1:0] THERM_OK    = 2'd0;
  localparam logic [1:0] THERM_COLD  = 2'd1;
  localparam logic [1:0] THERM_UNDER = 2'd2;
  localparam logic [1:0] THERM_HOT   = 2'd3;

  function automatic logic [15:0] vCeilMv(input logic [2:0] sel);
    case (sel)
      3'd0:    return 16'd8400;
      3'd1:    return 16'd12600;
      3'd2:    return 16'd16800;
      3'd3:    return 16'd21000;
      default: return 16'd32736;
    endcase
  endfunction

  function automatic logic [2:0] vStepShift(input logic [2:0] sel);
    return (sel < 3'd2) ? 3'd4 : 3'd5;
  endfunction

  function automatic logic [9:0] vCeilCode(input logic [2:0] sel);
    logic [15:0] q;
    q = vCeilMv(sel) >> vStepShift(sel);
    return q[9:0];
  endfunction

endpackage

// File: rtl/chargeReqFsm.sv
`timescale 1ns/1ps
module chargeReqFsm
  import chargeReqPkg::*;
#(
  parameter int PRESCALE      = 100000,
  parameter int TIMEOUT_TICKS = 17500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqCurWr,
  input  logic       reqVoltWr,
  input  logic       batPresent,
  input  logic [1:0] thermState,
  output chgCtl_t    ctl
);

  localparam int PRE_W  = $clog2(PRESCALE + 1);
  localparam int TICK_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRESCALE - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TIMEOUT_TICKS - 1);

  typedef enum logic [1:0] {ST_WAIT, ST_WAKE, ST_CHARGE, ST_STOP} state_e;

  state_e st, stNext;
  logic curSeen, voltSeen, pairDone, coolish, restart, timeout, timing;
  logic [PRE_W-1:0]  preCnt;
  logic [TICK_W-1:0] tickCnt;

  assign pairDone = (curSeen || reqCurWr) && (voltSeen || reqVoltWr);
  assign coolish  = (thermState == THERM_COLD) || (thermState == THERM_UNDER);
  assign timing   = (st == ST_WAKE) || (st == ST_CHARGE);
  assign timeout  = timing && (preCnt == PRE_LAST) && (tickCnt == TICK_LAST);

  always_comb begin
    stNext  = st;
    restart = 1'b0;
    if (!batPresent) begin
      stNext = ST_WAIT;
    end else begin
      case (st)
        ST_WAIT: begin
          stNext  = ST_WAKE;
          restart = 1'b1;
        end
        ST_WAKE: begin
          if (pairDone && !coolish) begin
            stNext  = ST_CHARGE;
            restart = 1'b1;
          end else if (timeout) begin
            stNext = ST_STOP;
          end
        end
        ST_CHARGE: begin
          if (coolish || timeout) begin
            stNext  = ST_WAKE;
            restart = 1'b1;
          end else if (pairDone) begin
            restart = 1'b1;
          end
        end
        default: begin
          if (pairDone && !coolish) begin
            stNext  = ST_CHARGE;
            restart = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_WAIT;
      curSeen  <= 1'b0;
      voltSeen <= 1'b0;
    end else begin
      st <= stNext;
      if (st == ST_WAIT || !batPresent || pairDone) begin
        curSeen  <= 1'b0;
        voltSeen <= 1'b0;
      end else begin
        if (reqCurWr)  curSeen  <= 1'b1;
        if (reqVoltWr) voltSeen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (restart || !timing) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
      if (tickCnt != TICK_LAST) tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.outSel = SEL_OFF;
    if (batPresent && thermState != THERM_HOT) begin
      case (st)
        ST_WAKE:   ctl.outSel = SEL_WAKE;
        ST_CHARGE: ctl.outSel = SEL_REQ;
        default:   ctl.outSel = SEL_OFF;
      endcase
    end
  end

endmodule

// File: rtl/chargeReqDatapath.sv
`timescale 1ns/1ps
module chargeReqDatapath
  import chargeReqPkg::*;
#(
  parameter int REQ_W   = 16,
  parameter int CODE_W  = 10,
  parameter int WAKE_MA = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  chgCtl_t           ctl,
  input  logic              reqCurWr,
  input  logic              reqVoltWr,
  input  logic [REQ_W-1:0]  reqData,
  input  logic [1:0]        iRangeSel,
  input  logic [2:0]        vRangeSel,
  input  logic              batPresent,
  input  logic [1:0]        thermState,
  input  logic              acPresent,
  input  logic              pwrFailCmp,
  input  logic              statusRd,
  output logic [CODE_W-1:0] iDacCode,
  output logic [CODE_W-1:0] vDacCode,
  output logic              chgEn,
  output logic              intN,
  output logic [7:0]        statusWord
);

  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [REQ_W-1:0] reqCur, reqVolt;
  logic [REQ_W-1:0] iCeil, vCeil, curClamp, voltClamp, curShift, voltShift, wakeShift, vCeilShift;
  logic             curOver, voltOver, enNext, intPend;
  logic [CODE_W-1:0] nextI, nextV;
  logic [7:0]       statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqCur  <= '0;
      reqVolt <= '0;
    end else begin
      if (reqCurWr)  reqCur  <= reqData;
      if (reqVoltWr) reqVolt <= reqData;
    end
  end

  assign iCeil      = REQ_W'(CODE_MAX) << iRangeSel;
  assign vCeil      = REQ_W'(vCeilMv(vRangeSel));
  assign curOver    = reqCur > iCeil;
  assign voltOver   = reqVolt > vCeil;
  assign curClamp   = curOver ? iCeil : reqCur;
  assign voltClamp  = voltOver ? vCeil : reqVolt;
  assign curShift   = curClamp >> iRangeSel;
  assign voltShift  = voltClamp >> vStepShift(vRangeSel);
  assign wakeShift  = REQ_W'(WAKE_MA) >> iRangeSel;
  assign vCeilShift = vCeil >> vStepShift(vRangeSel);

  always_comb begin
    case (ctl.outSel)
      SEL_WAKE: begin
        nextI = CODE_W'(wakeShift);
        nextV = CODE_W'(vCeilShift);
      end
      SEL_REQ: begin
        nextI = CODE_W'(curShift);
        nextV = CODE_W'(voltShift);
      end
      default: begin
        nextI = '0;
        nextV = '0;
      end
    endcase
    enNext = (ctl.outSel != SEL_OFF) && (nextI != '0) && (nextV != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iDacCode <= '0;
      vDacCode <= '0;
      chgEn    <= 1'b0;
    end else begin
      iDacCode <= nextI;
      vDacCode <= nextV;
      chgEn    <= enNext;
    end
  end

  assign statusNext = {thermState == THERM_HOT, thermState == THERM_UNDER,
                       thermState == THERM_COLD, pwrFailCmp, voltOver, curOver,
                       acPresent, batPresent};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusWord <= '0;
      intPend    <= 1'b0;
    end else begin
      statusWord <= statusNext;
      if (statusNext != statusWord) intPend <= 1'b1;
      else if (statusRd)            intPend <= 1'b0;
    end
  end

  assign intN = ~intPend;

endmodule

// File: rtl/chargeReqCtl.sv
`timescale 1ns/1ps
module chargeReqCtl
  import chargeReqPkg::*;
#(
  parameter int PRESCALE      = 100000,
  parameter int TIMEOUT_TICKS = 17500,
  parameter int WAKE_MA       = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqCurWr,
  input  logic        reqVoltWr,
  input  logic [15:0] reqData,
  input  logic [1:0]  iRangeSel,
  input  logic [2:0]  vRangeSel,
  input  logic        batPresent,
  input  logic [1:0]  thermState,
  input  logic        acPresent,
  input  logic        pwrFailCmp,
  input  logic        statusRd,
  output logic [9:0]  iDacCode,
  output logic [9:0]  vDacCode,
  output logic        chgEn,
  output logic        intN,
  output logic [7:0]  statusWord
);

  chgCtl_t ctl;

  chargeReqFsm #(.PRESCALE(PRESCALE), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_fsm (
    .clk(clk), .rstN(rstN), .reqCurWr(reqCurWr), .reqVoltWr(reqVoltWr),
    .batPresent(batPresent), .thermState(thermState), .ctl(ctl)
  );

  chargeReqDatapath #(.REQ_W(16), .CODE_W(10), .WAKE_MA(WAKE_MA)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqCurWr(reqCurWr), .reqVoltWr(reqVoltWr),
    .reqData(reqData), .iRangeSel(iRangeSel), .vRangeSel(vRangeSel),
    .batPresent(batPresent), .thermState(thermState), .acPresent(acPresent),
    .pwrFailCmp(pwrFailCmp), .statusRd(statusRd), .iDacCode(iDacCode),
    .vDacCode(vDacCode), .chgEn(chgEn), .intN(intN), .statusWord(statusWord)
  );

endmodule

// File: rtl/chargeReqChk.sv
`timescale 1ns/1ps
module chargeReqChk
  import chargeReqPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       batPresent,
  input logic [1:0] thermState,
  input logic [2:0] vRangeSel,
  input logic       statusRd,
  input logic [7:0] statusWord,
  input logic       intN,
  input logic       chgEn,
  input logic [9:0] iDacCode,
  input logic [9:0] vDacCode
);

  a_r11_removed_off: assert property (@(posedge clk) disable iff (!rstN)
    !batPresent |=> (iDacCode == 10'd0 && vDacCode == 10'd0 && !chgEn));

  a_r10_hot_off: assert property (@(posedge clk) disable iff (!rstN)
    (thermState == THERM_HOT) |=> (!chgEn && iDacCode == 10'd0));

  a_r13_change_raises: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord != $past(statusWord)) |-> !intN);

  a_r13_hold_until_read: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !statusRd) |=> !intN);

  a_r4_volt_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    vDacCode <= vCeilCode($past(vRangeSel)));

  a_r6_enable_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    chgEn |-> (iDacCode != 10'd0 && vDacCode != 10'd0));

endmodule

bind chargeReqCtl chargeReqChk u_chk (
  .clk(clk), .rstN(rstN), .batPresent(batPresent), .thermState(thermState),
  .vRangeSel(vRangeSel), .statusRd(statusRd), .statusWord(statusWord),
  .intN(intN), .chgEn(chgEn), .iDacCode(iDacCode), .vDacCode(vDacCode)
);

// File: tb/chargeReqCtl_tb.sv
`timescale 1ns/1ps
module chargeReqCtl_tb;

  localparam int PRE = 4;
  localparam int TO  = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqCurWr = 1'b0, reqVoltWr = 1'b0;
  logic [15:0] reqData = '0;
  logic [1:0] iRangeSel = '0;
  logic [2:0] vRangeSel = '0;
  logic batPresent = 1'b0, acPresent = 1'b0, pwrFailCmp = 1'b0, statusRd = 1'b0;
  logic [1:0] thermState = '0;
  logic [9:0] iDacCode, vDacCode;
  logic chgEn, intN;
  logic [7:0] statusWord;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chargeReqCtl #(.PRESCALE(PRE), .TIMEOUT_TICKS(TO), .WAKE_MA(80)) u_dut (
    .clk(clk), .rstN(rstN), .reqCurWr(reqCurWr), .reqVoltWr(reqVoltWr),
    .reqData(reqData), .iRangeSel(iRangeSel), .vRangeSel(vRangeSel),
    .batPresent(batPresent), .thermState(thermState), .acPresent(acPresent),
    .pwrFailCmp(pwrFailCmp), .statusRd(statusRd), .iDacCode(iDacCode),
    .vDacCode(vDacCode), .chgEn(chgEn), .intN(intN), .statusWord(statusWord)
  );

  int vCeilB[5] = '{8400, 12600, 16800, 21000, 32736};
  int vShB[5]   = '{4, 4, 5, 5, 5};

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writePair(input int cur, input int volt);
    @(negedge clk); reqCurWr = 1'b1; reqData = 16'(cur);
    @(negedge clk); reqCurWr = 1'b0; reqVoltWr = 1'b1; reqData = 16'(volt);
    @(negedge clk); reqVoltWr = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    int curVals[14] = '{0, 1, 7, 80, 1000, 1023, 1024, 2046, 2047, 4092, 5000, 8184, 9000, 65535};
    int voltVals[12] = '{0, 16, 8399, 8400, 8416, 12600, 12700, 16800, 21000, 21050, 32736, 40000};
    cyc(5);
    rstN = 1'b1;
    cyc(2);
    chk("R1 iDac", iDacCode, 0);
    chk("R1 vDac", vDacCode, 0);
    chk("R1 chgEn", chgEn, 0);
    chk("R1 intN", intN, 1);
    chk("R1 status", statusWord, 0);

    iRangeSel = 2'd0; vRangeSel = 3'd1;
    batPresent = 1'b1; acPresent = 1'b1;
    cyc(2);
    chk("R2 wake iDac", iDacCode, 80);
    chk("R2 wake vDac", vDacCode, 787);
    chk("R2 wake chgEn", chgEn, 1);
    chk("R12 presence bits", statusWord, 3);
    chk("R13 intN on change", intN, 0);
    readStatus();
    chk("R13 intN after read", intN, 1);
    iRangeSel = 2'd2;
    cyc(1);
    chk("R2 wake step sel2", iDacCode, 20);
    iRangeSel = 2'd0;

    @(negedge clk); reqCurWr = 1'b1; reqData = 16'd500;
    @(negedge clk); reqCurWr = 1'b0;
    cyc(2);
    chk("R2 single write stays wake", iDacCode, 80);
    @(negedge clk); reqVoltWr = 1'b1; reqData = 16'd8400;
    @(negedge clk); reqVoltWr = 1'b0;
    cyc(1);
    chk("R3 pair iDac", iDacCode, 500);
    chk("R3 pair vDac", vDacCode, 525);

    // current sweep
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 14; k++) begin
        int ceil, expI;
        iRangeSel = 2'(s); vRangeSel = 3'd1;
        ceil = 1023 << s;
        expI = minI(curVals[k], ceil) >> s;
        writePair(curVals[k], 8400);
        cyc(1);
        chk($sformatf("R3 iDac sel%0d req%0d", s, curVals[k]), iDacCode, expI);
        chk($sformatf("R6 chgEn sel%0d req%0d", s, curVals[k]), chgEn, (expI != 0) ? 1 : 0);
        chk($sformatf("R5 curOR sel%0d req%0d", s, curVals[k]), statusWord[2], (curVals[k] > ceil) ? 1 : 0);
      end
    end

    // voltage sweep
    for (int s = 0; s < 5; s++) begin
      for (int k = 0; k < 12; k++) begin
        int expV;
        iRangeSel = 2'd0; vRangeSel = 3'(s);
        expV = minI(voltVals[k], vCeilB[s]) >> vShB[s];
        writePair(1000, voltVals[k]);
        cyc(1);
        chk($sformatf("R4 vDac sel%0d req%0d", s, voltVals[k]), vDacCode, expV);
        chk($sformatf("R6 chgEn vsel%0d req%0d", s, voltVals[k]), chgEn, (expV != 0) ? 1 : 0);
        chk($sformatf("R5 voltOR sel%0d req%0d", s, voltVals[k]), statusWord[3], (voltVals[k] > vCeilB[s]) ? 1 : 0);
      end
    end

    // timeouts
    iRangeSel = 2'd0; vRangeSel = 3'd1;
    writePair(1000, 12000);
    cyc(150);
    chk("R7 before timeout", iDacCode, 1000);
    cyc(60);
    chk("R7 fallback iDac", iDacCode, 80);
    chk("R7 fallback vDac", vDacCode, 787);
    cyc(200);
    chk("R8 wake timeout iDac", iDacCode, 0);
    chk("R8 wake timeout chgEn", chgEn, 0);
    writePair(1000, 12000);
    cyc(1);
    chk("R8 resume iDac", iDacCode, 1000);
    chk("R8 resume vDac", vDacCode, 750);

    // thermistor cold / under-range
    thermState = 2'd1;
    cyc(2);
    chk("R9 cold to wake", iDacCode, 80);
    chk("R9 cold bit", statusWord[5], 1);
    writePair(600, 8000);
    cyc(1);
    chk("R9 cold holds wake", iDacCode, 80);
    thermState = 2'd2;
    writePair(600, 8000);
    cyc(1);
    chk("R9 under holds wake", iDacCode, 80);
    chk("R9 under bit", statusWord[6], 1);
    thermState = 2'd0;
    writePair(600, 8000);
    cyc(1);
    chk("R9 normal charge", iDacCode, 600);

    // hot
    thermState = 2'd3;
    cyc(1);
    chk("R10 hot chgEn", chgEn, 0);
    chk("R10 hot iDac", iDacCode, 0);
    chk("R10 hot vDac", vDacCode, 0);
    chk("R10 hot bit", statusWord[7], 1);
    thermState = 2'd0;
    cyc(1);
    chk("R10 hot released", iDacCode, 600);

    // power fail together with a read
    readStatus();
    chk("R13 cleared", intN, 1);
    @(negedge clk); statusRd = 1'b1; pwrFailCmp = 1'b1;
    @(negedge clk); statusRd = 1'b0;
    chk("R13 change beats read", intN, 0);
    chk("R12 power fail bit", statusWord[4], 1);
    pwrFailCmp = 1'b0;
    readStatus();
    acPresent = 1'b0;
    cyc(1);
    chk("R13 adapter change", intN, 0);
    chk("R12 adapter bit", statusWord[1], 0);

    // removal and reinsertion
    batPresent = 1'b0;
    cyc(1);
    chk("R11 removal iDac", iDacCode, 0);
    chk("R11 removal vDac", vDacCode, 0);
    chk("R11 removal chgEn", chgEn, 0);
    cyc(3);
    batPresent = 1'b1;
    cyc(2);
    chk("R11 reinsert wake", iDacCode, 80);
    chk("R11 reinsert chgEn", chgEn, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule